// File: doc/BRIEF.md
# Serial clock-calendar register slave

This block is the register side of a timekeeping peripheral, reached over a four-wire serial link. A host raises the chip enable, shifts in one address byte and then any number of data bytes. Bit 7 of the address byte picks the direction and bits 6:0 pick the first register. Each data byte after that moves to the next register. The bank holds the time and date fields, two alarm sets, a control register, a status register, a charger setting and a block of user RAM. All of them are plain byte storage. The one exception is a protect bit in the control register, which locks out writes.

The serial pins are oversampled by the block clock through synchronizers. The link has no flow control: the host sets the pace and the slave never stalls it, so no back-pressure rule applies. A parallel peek port reads any register combinationally, for system-side observation.

Top module: `clkcal_spi_slave`

## Requirements
- R1: After reset every register reads 0x00 on the peek port and `miso` is low.
- R2: A transaction runs while `ce` is high. Bits travel MSB first and are taken on the rising edge of `sclk`, which idles high. An address byte with bit 7 set starts a write: the next full byte is stored at the address held in bits 6:0.
- R3: Each further full data byte in one transaction goes to the next address. The address counts modulo 128, so 0x7F is followed by 0x00.
- R4: An address byte with bit 7 clear starts a read. From the byte after the address onward, `miso` carries the contents of consecutive registers, MSB first. Each bit is updated after a falling edge of `sclk` and is valid at the next rising edge.
- R5: At every rising `sclk` edge of an address byte or of a write transaction, `miso` is low. It is also low while `ce` is low.
- R6: Addresses 0x12 to 0x1F, and addresses past the end of user RAM (the RAM starts at 0x20 and has RAM_DEPTH bytes), read as 0x00 on both ports. Writes to them are dropped.
- R7: While bit 6 of the control register (address 0x0F) is set, writes to every address other than 0x0F leave the register unchanged.
- R8: While bit 6 of the control register is set, a write to 0x0F changes only bit 6. Writing 0x00 therefore clears the protection and keeps the other control bits, so a second write is needed to clear them.
- R9: While bit 6 of the control register is clear, a write to 0x0F stores the whole byte.
- R10: A byte cut short by `ce` falling is discarded. The next transaction starts again with an address byte.
- R11: `peek_data` shows, in the same cycle, the contents of the register at `peek_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Chip enable, active high, frames a transaction |
| sclk | input | 1 | Serial clock, idles high |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| peek_addr | input | 7 | Parallel read address |
| peek_data | output | 8 | Contents at peek_addr |

## Verification
The bench aims at the protect rules. It writes to a locked register, writes the control register twice to unlock and then clear it, and runs a burst that crosses the control register while protection is on. A design that decoded protection per transaction instead of per byte, or that cleared every control bit in one write, would leave a register differing from the model. Bursts are run across the 0x7F boundary, into the unimplemented gap and into RAM, which catches a wrong wrap or a missing address decode. Bytes cut short by `ce` falling catch a design that commits a byte before all eight bits have arrived. Reads catch a data byte that starts one bit early or late on `miso`.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int CTRL_IDX = 15;   // control register location
  localparam int WP_BIT   = 6;    // protect bit inside control
  localparam int SYS_LAST = 17;   // last fixed register
  localparam int RAM_BASE = 32;   // first user RAM byte
  typedef enum logic {PH_ADDR, PH_DATA} phase_e;
endpackage

// File: rtl/clkcal_spi_front.sv
module clkcal_spi_front
  import clkcal_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              sclk,
  input  logic              mosi,
  input  logic [DATA_W-1:0] tx_val,
  input  logic              tx_en,
  output logic              ce_on,
  output logic              byte_vld,
  output logic [DATA_W-1:0] byte_val,
  output logic              miso
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [SYNC_STAGES-1:0] ce_p, sck_p, dat_p;
  logic                   sck_q;
  logic [CNT_W-1:0]       bitcnt;
  logic [DATA_W-1:0]      rx_sh, tx_sh;
  logic                   sck_s, dat_s, sck_rise, sck_fall;

  assign ce_on    = ce_p[SYNC_STAGES-1];
  assign sck_s    = sck_p[SYNC_STAGES-1];
  assign dat_s    = dat_p[SYNC_STAGES-1];
  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign miso     = tx_en & tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_p     <= '0;
      sck_p    <= '1;
      dat_p    <= '0;
      sck_q    <= 1'b1;
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      byte_vld <= 1'b0;
      byte_val <= '0;
    end else begin
      ce_p     <= {ce_p[SYNC_STAGES-2:0], ce};
      sck_p    <= {sck_p[SYNC_STAGES-2:0], sclk};
      dat_p    <= {dat_p[SYNC_STAGES-2:0], mosi};
      sck_q    <= sck_s;
      byte_vld <= 1'b0;
      if (!ce_on) begin
        bitcnt <= '0;
      end else begin
        if (sck_rise) begin
          rx_sh  <= {rx_sh[DATA_W-2:0], dat_s};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == CNT_W'(DATA_W - 1)) begin
            byte_vld <= 1'b1;
            byte_val <= {rx_sh[DATA_W-2:0], dat_s};
          end
        end
        if (sck_fall) begin
          if (bitcnt == '0) tx_sh <= tx_val;
          else              tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/clkcal_regbank.sv
module clkcal_regbank
  import clkcal_pkg::*;
#(
  parameter int RAM_DEPTH = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  output logic [DATA_W-1:0] ctrl_q
);
  localparam int NUM = 2 ** ADDR_W;
  localparam logic [DATA_W-1:0] WP_MASK = DATA_W'(1 << WP_BIT);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_IDX);

  logic [DATA_W-1:0] mem [NUM];
  logic [NUM-1:0]    live;
  logic              locked;

  for (genvar g = 0; g < NUM; g++) begin : g_map
    assign live[g] = (g <= SYS_LAST) || (g >= RAM_BASE && g < RAM_BASE + RAM_DEPTH);
  end

  assign ctrl_q = mem[CTRL_IDX];
  assign locked = ctrl_q[WP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) mem[i] <= '0;
    end else if (wr_en && live[wr_addr]) begin
      if (wr_addr == CTRL_A) begin
        if (locked) mem[wr_addr] <= (ctrl_q & ~WP_MASK) | (wr_data & WP_MASK);
        else        mem[wr_addr] <= wr_data;
      end else if (!locked) begin
        mem[wr_addr] <= wr_data;
      end
    end
  end

  assign rd_a_data = live[rd_a_addr] ? mem[rd_a_addr] : '0;
  assign rd_b_data = live[rd_b_addr] ? mem[rd_b_addr] : '0;
endmodule

// File: rtl/clkcal_spi_slave.sv
module clkcal_spi_slave
  import clkcal_pkg::*;
#(
  parameter int RAM_DEPTH   = 96,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [DATA_W-1:0] peek_data
);
  phase_e            phase;
  logic              is_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic              ce_on, byte_vld, wr_en, tx_en;
  logic [DATA_W-1:0] byte_val, bank_rd, tx_val, ctrl_q;

  clkcal_spi_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .mosi(mosi),
    .tx_val(tx_val), .tx_en(tx_en), .ce_on(ce_on),
    .byte_vld(byte_vld), .byte_val(byte_val), .miso(miso)
  );

  clkcal_regbank #(.RAM_DEPTH(RAM_DEPTH)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(cur_addr),
    .wr_data(byte_val), .rd_a_addr(cur_addr), .rd_a_data(bank_rd),
    .rd_b_addr(peek_addr), .rd_b_data(peek_data), .ctrl_q(ctrl_q)
  );

  assign wr_en  = byte_vld && ce_on && (phase == PH_DATA) && is_wr;
  assign tx_en  = (phase == PH_DATA) && !is_wr;
  assign tx_val = (phase == PH_DATA) ? bank_rd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_ADDR;
      is_wr    <= 1'b0;
      cur_addr <= '0;
    end else if (!ce_on) begin
      phase <= PH_ADDR;
    end else if (byte_vld) begin
      if (phase == PH_ADDR) begin
        cur_addr <= byte_val[ADDR_W-1:0];
        is_wr    <= byte_val[DATA_W-1];
        phase    <= PH_DATA;
      end else begin
        cur_addr <= cur_addr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkcal_spi_slave_chk.sv
module clkcal_spi_slave_chk
  import clkcal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ce_on,
  input logic              miso,
  input logic              byte_vld,
  input logic              in_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [ADDR_W-1:0] peek_addr,
  input logic [DATA_W-1:0] peek_data
);
  localparam logic [DATA_W-1:0] KEEP = ~DATA_W'(1 << WP_BIT);
  localparam logic [ADDR_W-1:0] CA   = ADDR_W'(CTRL_IDX);

  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_on && !$past(ce_on)) |-> !miso); // R5
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && in_data && ce_on) |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1)); // R3
  AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cur_addr == CA && ctrl_q[WP_BIT]) |=> (ctrl_q & KEEP) == ($past(ctrl_q) & KEEP)); // R8
  AST_OPEN_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cur_addr == CA && !ctrl_q[WP_BIT]) |=> ctrl_q == $past(wr_data)); // R9
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(peek_addr) > SYS_LAST && int'(peek_addr) < RAM_BASE) |-> peek_data == '0); // R6
endmodule

bind clkcal_spi_slave clkcal_spi_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ce_on(ce_on), .miso(miso),
  .byte_vld(byte_vld), .in_data(phase == clkcal_pkg::PH_DATA), .wr_en(wr_en),
  .cur_addr(cur_addr), .wr_data(byte_val), .ctrl_q(ctrl_q),
  .peek_addr(peek_addr), .peek_data(peek_data)
);

// File: tb/clkcal_spi_slave_tb_top.sv
module clkcal_spi_slave_tb_top;
  localparam int H = 6;
  localparam int RAM_DEPTH = 96;

  logic clk = 1'b0;
  logic rst_n, ce, sclk, mosi;
  logic miso;
  logic [6:0] peek_addr;
  logic [7:0] peek_data;
  int total = 0, bad = 0;
  logic [7:0] model [128];
  logic [7:0] wbuf  [16];

  always #4 clk = ~clk;

  clkcal_spi_slave #(.RAM_DEPTH(RAM_DEPTH), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .mosi(mosi),
    .miso(miso), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit live(input int a);
    return (a <= 17) || (a >= 32 && a < 32 + RAM_DEPTH);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void model_write(input int a, input logic [7:0] d);
    if (!live(a)) return;
    if (a == 15) begin
      if (model[15][6]) model[15][6] = d[6];
      else              model[15]    = d;
    end else if (!model[15][6]) begin
      model[a] = d;
    end
  endfunction

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      sclk = 1'b0; mosi = tx[i];
      tick(H);
      rx[i] = miso;
      sclk = 1'b1;
      tick(H);
    end
  endtask

  task automatic txn(input logic [7:0] ab, input int n);
    logic [7:0] r;
    int a;
    ce = 1'b1; tick(H);
    spi_bits(ab, 8, r);
    check("R5 addr byte miso", r, 0);
    a = ab[6:0];
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = live(a) ? model[a] : 8'h00;
      spi_bits(wbuf[k], 8, r);
      if (ab[7]) begin
        model_write(a, wbuf[k]);
        check("R5 write miso", r, 0);
      end else begin
        check("R4 read byte", r, e);
      end
      a = (a + 1) % 128;
    end
    tick(H); ce = 1'b0; tick(4 * H);
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 128; a++) begin
      peek_addr = 7'(a);
      tick(1);
      check(tag, peek_data, live(a) ? model[a] : 8'h00);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    rst_n = 1'b0; ce = 1'b0; sclk = 1'b1; mosi = 1'b0; peek_addr = '0;
    tick(5); rst_n = 1'b1; tick(5);
    check("R1 miso after reset", miso, 0);
    sweep("R1 reset contents");

    // R2 single write, hours in 12-hour PM form
    wbuf[0] = 8'h72;
    txn(8'h82, 1);
    sweep("R2 single write");

    // R3 burst write of time fields
    wbuf[0] = 8'h59; wbuf[1] = 8'h34; wbuf[2] = 8'h23; wbuf[3] = 8'h07;
    wbuf[4] = 8'h31; wbuf[5] = 8'h12; wbuf[6] = 8'h99;
    txn(8'h80, 7);
    sweep("R3 burst write");

    // R4 burst read back
    txn(8'h00, 7);

    // R3 wrap 0x7F -> 0x00, then R4 read across wrap
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'h11;
    txn(8'hFE, 3);
    sweep("R3 address wrap");
    txn(8'h7F, 2);

    // R6 writes into the gap are dropped, reads give zero
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
    txn(8'h90, 3);
    sweep("R6 gap writes");
    txn(8'h10, 4);

    // R11 RAM through peek
    wbuf[0] = 8'h3C;
    txn(8'hA0, 1);
    peek_addr = 7'h20; tick(1);
    check("R11 peek RAM", peek_data, 8'h3C);

    // R9 full control write, then lock with the other bits set
    wbuf[0] = 8'h07;
    txn(8'h8F, 1);
    sweep("R9 open control write");
    wbuf[0] = 8'h47;
    txn(8'h8F, 1);
    peek_addr = 7'h0F; tick(1);
    check("R9 control locked value", peek_data, 8'h47);

    // R7 locked writes ignored
    wbuf[0] = 8'h99;
    txn(8'h81, 1);
    wbuf[0] = 8'hEE;
    txn(8'hA0, 1);
    sweep("R7 locked writes");

    // R8 first clear keeps other bits
    wbuf[0] = 8'h00;
    txn(8'h8F, 1);
    peek_addr = 7'h0F; tick(1);
    check("R8 unlock keeps bits", peek_data, 8'h07);
    wbuf[0] = 8'h33;
    txn(8'h81, 1);
    sweep("R7 write after unlock");
    wbuf[0] = 8'h00;
    txn(8'h8F, 1);
    peek_addr = 7'h0F; tick(1);
    check("R9 second clear", peek_data, 8'h00);

    // R8 burst crossing control while locked
    wbuf[0] = 8'h40;
    txn(8'h8F, 1);
    wbuf[0] = 8'h5E; wbuf[1] = 8'h80; wbuf[2] = 8'h6D;
    txn(8'h8E, 3);
    sweep("R8 locked burst across control");

    // R10 partial bytes discarded
    ce = 1'b1; tick(H);
    spi_bits(8'h85, 8, r);
    spi_bits(8'h11, 8, r);
    model_write(5, 8'h11);
    spi_bits(8'hF0, 4, r);
    tick(H); ce = 1'b0; tick(4 * H);
    sweep("R10 partial data byte");
    ce = 1'b1; tick(H);
    spi_bits(8'h86, 5, r);
    tick(H); ce = 1'b0; tick(4 * H);
    wbuf[0] = 8'h42;
    txn(8'h86, 1);
    sweep("R10 restart after partial address");
    check("R5 miso idle", miso, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule